// File: doc/BRIEF.md
# Zero-Suppressed Hit Frame Builder

This block takes one sampling window at a time, made of a timestamp plus a sample word and a hit flag for each of up to sixteen channels. It turns that window into a short frame that carries only the channels that fired. The frame opens with the timestamp. After it comes one record per fired channel, and each record pairs the channel index with that channel's sample word. A window in which nothing fired is consumed silently and yields no frame.

Frames leave as a stream of fixed-width words with start-of-frame and end-of-frame markers under a valid/ready handshake. The block holds one window at a time. It takes the next window only after the last word of the current frame has been accepted downstream. While it waits on a stalled sink it holds its output and loses nothing. With the default widths each word is 20 bits wide, so a window with three fired channels costs 16 + 3 × 20 = 76 payload bits. A typical single-photon pulse spans two such windows, for 152 bits in total.

Top module: `zs_frame_builder`

## Requirements
- R1: After reset, `win_ready` is 1 and `out_valid` is 0.
- R2: A window accepted with `win_hits` all zero produces no output word, and the block is ready for a new window on the next cycle.
- R3: The cycle after a window with at least one hit is accepted, the first word of its frame is presented. This word has `out_first` = 1, the timestamp in bits [15:0] and zeros in bits [19:16].
- R4: Every word after the first is a channel record. Bits [19:16] hold the channel number and bits [15:0] hold that channel's sample word from the accepted window.
- R5: Records appear only for channels whose hit flag was 1. They appear in strictly ascending channel order and skip the channels that did not fire.
- R6: A frame has exactly 1 + (number of hits) words. `out_last` is 1 on the final word only. Three hits give four words, that is 76 payload bits.
- R7: From the accepting edge until the final word is accepted, `win_ready` is 0 and an offered window is not taken. That window is taken on the first edge after the frame ends.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output word and its markers stay unchanged, and no word is dropped or repeated.
- R9: A window with all sixteen channels fired is emitted in full, channels 0 to 15, in 17 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_valid | input | 1 | A window is offered |
| win_ready | output | 1 | The block can take a window |
| win_ts | input | TS_W (16) | Window timestamp |
| win_hits | input | NUM_CH (16) | Per-channel hit flag, bit c for channel c |
| win_data | input | NUM_CH*DATA_W (256) | Sample words, channel c in bits [c*16 +: 16] |
| out_valid | output | 1 | An output word is presented |
| out_ready | input | 1 | The sink takes the word |
| out_data | output | WORD_W (20) | Timestamp word or channel record |
| out_first | output | 1 | Marks the timestamp word |
| out_last | output | 1 | Marks the final record of a frame |

## Verification
The bench builds the block with its default parameters: sixteen channels, 16-bit timestamp and 16-bit samples. The 4-bit index field is therefore fully used, and masks with channel 15 alone, all channels set, and sparse gaps such as 0, 2, 3 can all be reached. Random masks with random sink stalls test ordering, frame length and hold-under-stall together. A window offered while a frame is still draining tests the one-window-at-a-time rule.

// File: rtl/zsf_pkg.sv
package zsf_pkg;
    typedef enum logic [1:0] {
        ZS_IDLE = 2'd0,
        ZS_HEAD = 2'd1,
        ZS_BODY = 2'd2
    } zs_phase_e;
endpackage

// File: rtl/zsf_lowest_pick.sv
// Finds the lowest set bit of a pending mask; NUM >= 2.
module zsf_lowest_pick #(
    parameter int NUM = 16,
    parameter int IW  = $clog2(NUM)
) (
    input  logic [NUM-1:0] mask,
    output logic [IW-1:0]  idx,
    output logic [NUM-1:0] onehot,
    output logic           single
);
    always_comb begin
        onehot = mask & (~mask + NUM'(1));
        single = (mask != '0) && ((mask & (mask - NUM'(1))) == '0);
        idx    = '0;
        for (int i = 0; i < NUM; i++) begin
            if (onehot[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/zsf_window_reg.sv
// Holds the timestamp and per-channel samples of the window being framed.
module zsf_window_reg #(
    parameter int NUM    = 16,
    parameter int TS_W   = 16,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [TS_W-1:0]       ts_in,
    input  logic [NUM*DATA_W-1:0] data_in,
    output logic [TS_W-1:0]       ts_out,
    output logic [NUM*DATA_W-1:0] data_out
);
    logic [TS_W-1:0] ts_d, ts_q;

    always_comb ts_d = load ? ts_in : ts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign ts_out = ts_q;

    for (genvar c = 0; c < NUM; c++) begin : g_ch
        logic [DATA_W-1:0] smp_d, smp_q;

        always_comb smp_d = load ? data_in[c*DATA_W +: DATA_W] : smp_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) smp_q <= '0;
            else        smp_q <= smp_d;
        end

        assign data_out[c*DATA_W +: DATA_W] = smp_q;
    end
endmodule

// File: rtl/zs_frame_builder.sv
module zs_frame_builder #(
    parameter int NUM_CH = 16,
    parameter int TS_W   = 16,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(NUM_CH),
    parameter int WORD_W = IDX_W + DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     win_valid,
    output logic                     win_ready,
    input  logic [TS_W-1:0]          win_ts,
    input  logic [NUM_CH-1:0]        win_hits,
    input  logic [NUM_CH*DATA_W-1:0] win_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [WORD_W-1:0]        out_data,
    output logic                     out_first,
    output logic                     out_last
);
    import zsf_pkg::*;

    typedef struct packed {
        zs_phase_e         phase;
        logic [NUM_CH-1:0] pend;
    } zs_state_t;

    zs_state_t st_d, st_q;
    logic                     load;
    logic [TS_W-1:0]          cur_ts;
    logic [NUM_CH*DATA_W-1:0] cur_data;
    logic [IDX_W-1:0]         pick_idx;
    logic [NUM_CH-1:0]        pick_bit;
    logic                     pick_single;
    logic [DATA_W-1:0]        pick_data;

    zsf_window_reg #(.NUM(NUM_CH), .TS_W(TS_W), .DATA_W(DATA_W)) win_reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ts_in    (win_ts),
        .data_in  (win_data),
        .ts_out   (cur_ts),
        .data_out (cur_data)
    );

    zsf_lowest_pick #(.NUM(NUM_CH), .IW(IDX_W)) pick_i (
        .mask   (st_q.pend),
        .idx    (pick_idx),
        .onehot (pick_bit),
        .single (pick_single)
    );

    assign pick_data = cur_data[pick_idx*DATA_W +: DATA_W];

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q.phase)
            ZS_IDLE: begin
                if (win_valid && (win_hits != '0)) begin
                    load       = 1'b1;
                    st_d.pend  = win_hits;
                    st_d.phase = ZS_HEAD;
                end
            end
            ZS_HEAD: begin
                if (out_ready) st_d.phase = ZS_BODY;
            end
            ZS_BODY: begin
                if (out_ready) begin
                    st_d.pend = st_q.pend & ~pick_bit;
                    if (pick_single) st_d.phase = ZS_IDLE;
                end
            end
            default: st_d.phase = ZS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: ZS_IDLE, pend: '0};
        else        st_q <= st_d;
    end

    assign win_ready = (st_q.phase == ZS_IDLE);
    assign out_valid = (st_q.phase != ZS_IDLE);
    assign out_first = (st_q.phase == ZS_HEAD);
    assign out_last  = (st_q.phase == ZS_BODY) && pick_single;
    assign out_data  = (st_q.phase == ZS_HEAD) ? WORD_W'(cur_ts) : {pick_idx, pick_data};

    // R2
    empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_ready && (win_hits == '0)) |=> (win_ready && !out_valid));

    // R3
    frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_ready && (win_hits != '0)) |=> (out_valid && out_first));

    // R5
    ascend_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_first && !out_last)
        |=> (out_data[WORD_W-1 -: IDX_W] > $past(out_data[WORD_W-1 -: IDX_W])));

    // R6
    frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && win_ready));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_first) && $stable(out_last)));
endmodule

// File: tb/zs_frame_builder_tb.sv
module zs_frame_builder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int DW  = 16;
    localparam int TW  = 16;
    localparam int WW  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic win_valid = 1'b0;
    logic win_ready;
    logic [TW-1:0] win_ts = '0;
    logic [NCH-1:0] win_hits = '0;
    logic [NCH*DW-1:0] win_data = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [WW-1:0] out_data;
    logic out_first, out_last;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zs_frame_builder dut_i (
        .clk(clk), .rst_n(rst_n),
        .win_valid(win_valid), .win_ready(win_ready),
        .win_ts(win_ts), .win_hits(win_hits), .win_data(win_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_first(out_first), .out_last(out_last)
    );

    function automatic logic [DW-1:0] sample_of(int ch, logic [TW-1:0] ts);
        return (16'h5A00 + 16'(ch) * 16'h0111) ^ ts;
    endfunction

    function automatic int popc(logic [NCH-1:0] m);
        int k = 0;
        for (int i = 0; i < NCH; i++) if (m[i]) k++;
        return k;
    endfunction

    // word n of the expected frame: n=0 timestamp, n>=1 the n-th fired channel
    function automatic logic [WW-1:0] exp_word(logic [TW-1:0] ts, logic [NCH-1:0] m, int n);
        int k = 0;
        if (n == 0) return WW'(ts);
        for (int i = 0; i < NCH; i++) begin
            if (m[i]) begin
                k++;
                if (k == n) return {4'(i), sample_of(i, ts)};
            end
        end
        return '0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_window(input logic [TW-1:0] ts, input logic [NCH-1:0] m);
        win_ts = ts;
        win_hits = m;
        for (int c = 0; c < NCH; c++) win_data[c*DW +: DW] = sample_of(c, ts);
        win_valid = 1'b1;
    endtask

    // Offers a window, collects its frame and checks it word by word.
    task automatic run_frame(input logic [TW-1:0] ts, input logic [NCH-1:0] m,
                             input bit stall, input bit offer_next,
                             input logic [TW-1:0] nts, input logic [NCH-1:0] nm);
        int cnt = 1 + popc(m);
        int n = 0;
        bit busy_ok = 1'b1;
        bit prev_stall = 1'b0;
        logic [WW-1:0] held = '0;
        bit done = 1'b0;
        @(negedge clk);
        set_window(ts, m);
        #1;
        chk(win_ready == 1'b1, "R7", "ready before window", 32'(win_ready), 1);
        @(negedge clk);
        if (offer_next) set_window(nts, nm);
        else win_valid = 1'b0;
        if (m == '0) begin
            #1;
            // R2: empty window yields nothing
            chk(!out_valid && win_ready, "R2", "empty window valid/ready",
                {30'd0, out_valid, win_ready}, 32'h1);
            return;
        end
        for (int cyc = 0; cyc < 500 && !done; cyc++) begin
            out_ready = stall ? 1'($urandom % 2) : 1'b1;
            #1;
            if (out_valid && win_ready) busy_ok = 1'b0;
            if (prev_stall)
                chk(out_valid && out_data == held, "R8", "word held under stall",
                    32'(out_data), 32'(held));
            prev_stall = out_valid && !out_ready;
            held = out_data;
            if (out_valid && out_ready) begin
                // R3 on word 0, R4 and R5 on records
                chk(out_data == exp_word(ts, m, n), (n == 0) ? "R3" : "R4",
                    "word content", 32'(out_data), 32'(exp_word(ts, m, n)));
                chk(out_first == (n == 0) && out_last == (n == cnt - 1), "R6",
                    "first/last markers", {30'd0, out_first, out_last},
                    {30'd0, 1'(n == 0), 1'(n == cnt - 1)});
                n++;
                if (out_last) done = 1'b1;
            end
            if (!done) @(negedge clk);
        end
        out_ready = 1'b1;
        chk(n == cnt, "R6", "frame length in words", 32'(n), 32'(cnt));
        chk(busy_ok, "R7", "win_ready low while draining", 32'(!busy_ok), 0);
    endtask

    task automatic t_reset();
        #1;
        chk(win_ready == 1'b1 && out_valid == 1'b0, "R1", "reset state",
            {30'd0, win_ready, out_valid}, 32'h2);
    endtask

    task automatic t_empty();
        run_frame(16'h1234, '0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic t_sparse();
        // R5, R6: channels 0,2,3 -> 4 words, 76 bits; twice in a row -> 152 bits
        run_frame(16'h0100, 16'h000D, 1'b0, 1'b0, '0, '0);
        run_frame(16'h0101, 16'h000D, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic t_edges();
        run_frame(16'hFFFF, 16'h8000, 1'b0, 1'b0, '0, '0);   // R4 channel 15 alone
        run_frame(16'h0001, 16'h0001, 1'b0, 1'b0, '0, '0);   // channel 0 alone
        run_frame(16'hBEEF, 16'hFFFF, 1'b0, 1'b0, '0, '0);   // R9 all channels
    endtask

    task automatic t_stall();
        // R8 random sink stalls
        run_frame(16'h7777, 16'hA5A5, 1'b1, 1'b0, '0, '0);
        run_frame(16'h7778, 16'hFFFF, 1'b1, 1'b0, '0, '0);
    endtask

    task automatic t_busy();
        // R7: second window offered during the first frame is taken only after it
        run_frame(16'h2000, 16'h0C30, 1'b1, 1'b1, 16'h2001, 16'h4002);
        run_frame(16'h2001, 16'h4002, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic t_random();
        for (int k = 0; k < 40; k++) begin
            logic [NCH-1:0] m = 16'($urandom) & 16'($urandom);
            run_frame(16'($urandom), m, 1'b1, 1'b0, '0, '0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_empty();
        t_sparse();
        t_edges();
        t_stall();
        t_busy();
        t_random();
        t_empty();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R6 watchdog: actual cycles %0d expected below %0d", 100000, 100000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule